// File: doc/BRIEF.md
# Residual-Feedback Clamped Accumulator

This block accumulates a stream of signed increments into a bounded running value. There is no saturation inside the accumulation loop. Each cycle it estimates a residual instead: how far the raw sum has gone past the lower or upper bound. That residual is used in two places:

- It enters a delay line of `DEPTH` stages and is then added back into the raw accumulator. This lets the accumulator's zero base drift back toward the range without a single-cycle compare-and-clamp loop.
- It is added to a forward correction term, which maps the raw value back onto the true base. When a delayed residual re-enters the raw accumulator, the forward term gives up the same amount, so the visible result does not move.

The residual estimate uses only the current raw sum, the previous raw sum and the bound that was crossed. It is therefore an approximation, and the small errors it makes are accepted. A final hard clamp keeps every emitted value inside the bounds. The block suits feedback decoders, such as adaptive predictive audio decoders, where the saturating loop would otherwise limit the clock rate.

Top module: `resid_clamp_acc`

## Requirements
- R1: While `rst` is high, the raw accumulator, the forward correction and the delay line are cleared. During reset and after it, until the first sample, `y_o` holds 0 limited to [`LO`,`HI`].
- R2: While the running sum of all increments since reset stays within [`LO`,`HI`], `y_o` equals that running sum. It appears one clock after the increment is presented, for any `DEPTH`.
- R3: When the raw sum `r` exceeds `HI`, the residual is the smaller of 0 and (max(previous raw, `HI`) − `r`). A raw value that is still above `HI` but lower than the previous raw value therefore yields a residual of 0. Inside the range the residual is 0.
- R4: When the raw sum `r` is below `LO`, the residual is the larger of 0 and (min(previous raw, `LO`) − `r`).
- R5: `y_o` after each clock equals the sum of all increments plus the sum of all residuals since reset, limited to [`LO`,`HI`].
- R6: Each residual is added into the raw accumulator exactly `DEPTH` clocks after it is formed, and the forward correction drops by the same amount in that cycle. A cycle with a zero increment and a zero new residual leaves `y_o` unchanged, even when a delayed residual arrives.
- R7: `y_o` never leaves [`LO`,`HI`].
- R8: With bounds 0 and 88, `DEPTH` of 4 or more, and a start from reset, the increments +90, +8, −1, +2 produce the outputs 88, 88, 87, 87. The last value deviates from a true saturating accumulator by design.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inc_i | input | W | Signed increment applied at every clock |
| y_o | output | W | Signed corrected and clamped running value |

## Verification
The delicate case is a cycle in which a residual from `DEPTH` clocks earlier re-enters the raw accumulator while the same clock also forms a new residual from a fresh out-of-range step. The injection moves the raw value that the new estimate is computed from. A second instance with `DEPTH` of 1 is driven with consecutive overshooting steps, so that the two events coincide in almost every cycle. A depth-8 instance is driven with the same steps, so that they fall apart. Both outputs are compared against a bench model of the requirement arithmetic, and a checker confirms that an injection alone never moves the output.

// File: rtl/resacc_pkg.sv
package resacc_pkg;

   // Where the raw accumulator sits relative to the clamp range
   typedef enum logic [1:0] {
      ZONE_INSIDE = 2'd0,
      ZONE_ABOVE  = 2'd1,
      ZONE_BELOW  = 2'd2
   } zone_e;

   localparam int MAX_DEPTH = 32;

endpackage

// File: rtl/resacc_estimator.sv
// Residual estimate from two successive raw sums and the bound crossed.
module resacc_estimator
   import resacc_pkg::*;
#(
   parameter int AW = 24,
   parameter int LO = 0,
   parameter int HI = 88
) (
   input  logic signed [AW-1:0] raw_i,
   input  logic signed [AW-1:0] prev_i,
   output logic signed [AW-1:0] res_o
);

   localparam logic signed [AW-1:0] LO_A = AW'(LO);
   localparam logic signed [AW-1:0] HI_A = AW'(HI);

   zone_e                zone;
   logic signed [AW-1:0] ref_v;
   logic signed [AW-1:0] diff;

   always_comb begin
      if (raw_i > HI_A)      zone = ZONE_ABOVE;
      else if (raw_i < LO_A) zone = ZONE_BELOW;
      else                   zone = ZONE_INSIDE;
   end

   always_comb begin
      ref_v = '0;
      diff  = '0;
      res_o = '0;
      unique case (zone)
         ZONE_ABOVE: begin
            ref_v = (prev_i > HI_A) ? prev_i : HI_A;
            diff  = ref_v - raw_i;
            res_o = (diff < 0) ? diff : '0;
         end
         ZONE_BELOW: begin
            ref_v = (prev_i < LO_A) ? prev_i : LO_A;
            diff  = ref_v - raw_i;
            res_o = (diff > 0) ? diff : '0;
         end
         default: res_o = '0;
      endcase
   end

endmodule

// File: rtl/resacc_delay.sv
// Residual feedback delay line; depth picks the implementation.
module resacc_delay #(
   parameter int AW    = 24,
   parameter int DEPTH = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic signed [AW-1:0] d_i,
   output logic signed [AW-1:0] q_o
);

   generate
      if (DEPTH == 1) begin : g_single
         logic signed [AW-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (rst) stage_q <= '0;
            else     stage_q <= d_i;
         end
         assign q_o = stage_q;
      end else begin : g_chain
         logic signed [AW-1:0] pipe_q [DEPTH];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
            end else begin
               pipe_q[0] <= d_i;
               for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign q_o = pipe_q[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/resacc_clamp.sv
// Final hard limit of the corrected value to the output range.
module resacc_clamp #(
   parameter int AW = 24,
   parameter int W  = 16,
   parameter int LO = 0,
   parameter int HI = 88
) (
   input  logic signed [AW-1:0] v_i,
   output logic signed [W-1:0]  v_o
);

   localparam logic signed [AW-1:0] LO_A = AW'(LO);
   localparam logic signed [AW-1:0] HI_A = AW'(HI);

   always_comb begin
      if (v_i > HI_A)      v_o = HI_A[W-1:0];
      else if (v_i < LO_A) v_o = LO_A[W-1:0];
      else                 v_o = v_i[W-1:0];
   end

endmodule

// File: rtl/resid_clamp_acc.sv
module resid_clamp_acc
   import resacc_pkg::*;
#(
   parameter int W     = 16,
   parameter int GUARD = 8,
   parameter int LO    = 0,
   parameter int HI    = 32767,
   parameter int DEPTH = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic signed [W-1:0] inc_i,
   output logic signed [W-1:0] y_o
);

   localparam int AW    = W + GUARD;
   localparam int RST_Y = (LO > 0) ? LO : ((HI < 0) ? HI : 0);

   // elaboration-time parameter checks
   generate
      if (DEPTH < 1 || DEPTH > MAX_DEPTH) begin : g_bad_depth
         $error("resid_clamp_acc: DEPTH must lie in 1..32");
      end
      if (LO >= HI) begin : g_bad_bounds
         $error("resid_clamp_acc: LO must be below HI");
      end
      if (LO < -(2 ** (W-1)) || HI > (2 ** (W-1)) - 1) begin : g_bad_range
         $error("resid_clamp_acc: bounds do not fit the output width");
      end
      if (GUARD < 2) begin : g_bad_guard
         $error("resid_clamp_acc: GUARD needs at least two bits");
      end
   endgenerate

   logic signed [AW-1:0] acc_q;
   logic signed [AW-1:0] fwd_q;
   logic signed [AW-1:0] inc_ext;
   logic signed [AW-1:0] inj;
   logic signed [AW-1:0] raw;
   logic signed [AW-1:0] res;
   logic signed [AW-1:0] fwd_n;
   logic signed [AW-1:0] corr;
   logic signed [W-1:0]  y_n;
   logic signed [W-1:0]  y_q;

   assign inc_ext = {{GUARD{inc_i[W-1]}}, inc_i};

   // raw sum with floating base: increment plus residual returning from the delay line
   assign raw = acc_q + inc_ext + inj;

   resacc_estimator #(.AW(AW), .LO(LO), .HI(HI)) u_est (
      .raw_i  (raw),
      .prev_i (acc_q),
      .res_o  (res)
   );

   resacc_delay #(.AW(AW), .DEPTH(DEPTH)) u_dly (
      .clk (clk),
      .rst (rst),
      .d_i (res),
      .q_o (inj)
   );

   // forward correction: gains each new residual, gives back what re-enters the loop
   assign fwd_n = fwd_q - inj + res;
   assign corr  = raw + fwd_n;

   resacc_clamp #(.AW(AW), .W(W), .LO(LO), .HI(HI)) u_clamp (
      .v_i (corr),
      .v_o (y_n)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         fwd_q <= '0;
         y_q   <= W'(RST_Y);
      end else begin
         acc_q <= raw;
         fwd_q <= fwd_n;
         y_q   <= y_n;
      end
   end

   assign y_o = y_q;

endmodule

// File: rtl/resid_clamp_acc_chk.sv
module resid_clamp_acc_chk #(
   parameter int W     = 16,
   parameter int GUARD = 8,
   parameter int LO    = 0,
   parameter int HI    = 32767,
   parameter int DEPTH = 8
) (
   input logic                      clk,
   input logic                      rst,
   input logic signed [W-1:0]       inc_i,
   input logic signed [W-1:0]       y_o,
   input logic signed [W+GUARD-1:0] raw_i,
   input logic signed [W+GUARD-1:0] res_i,
   input logic signed [W+GUARD-1:0] inj_i
);

   localparam int AW = W + GUARD;
   localparam logic signed [AW-1:0] LO_A = AW'(LO);
   localparam logic signed [AW-1:0] HI_A = AW'(HI);
   localparam logic signed [W-1:0]  LO_W = W'(LO);
   localparam logic signed [W-1:0]  HI_W = W'(HI);

   assert_out_in_range_R7: assert property (@(posedge clk) disable iff (rst)
      (y_o >= LO_W) && (y_o <= HI_W))
      else $error("R7: output left the clamp range");

   // R3 above the range, R4 below it: residual sign tied to the bound crossed
   assert_res_sign_R3: assert property (@(posedge clk) disable iff (rst)
      (res_i != '0) |-> (((res_i < 0) && (raw_i > HI_A)) || ((res_i > 0) && (raw_i < LO_A))))
      else $error("R3/R4: residual with wrong sign or inside range");

   assert_res_bound_R3: assert property (@(posedge clk) disable iff (rst)
      (raw_i > HI_A) |-> ((raw_i + res_i) >= HI_A))
      else $error("R3: residual overshoots the upper bound");

   assert_res_bound_R4: assert property (@(posedge clk) disable iff (rst)
      (raw_i < LO_A) |-> ((raw_i + res_i) <= LO_A))
      else $error("R4: residual overshoots the lower bound");

   assert_inj_cancel_R6: assert property (@(posedge clk) disable iff (rst)
      ((inc_i == '0) && (res_i == '0)) |=> $stable(y_o))
      else $error("R6: returning residual moved the output");

   generate
      if (DEPTH == 1) begin : g_d1
         assert_d1_return_R6: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (inj_i == $past(res_i)))
            else $error("R6: residual did not return after one clock");
      end
   endgenerate

endmodule

bind resid_clamp_acc resid_clamp_acc_chk #(
   .W(W), .GUARD(GUARD), .LO(LO), .HI(HI), .DEPTH(DEPTH)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .inc_i (inc_i),
   .y_o   (y_o),
   .raw_i (raw),
   .res_i (res),
   .inj_i (inj)
);

// File: tb/resid_clamp_acc_test.sv
module resid_clamp_acc_test;

   localparam int CLK_PERIOD = 10;
   localparam int W    = 16;
   localparam int LO   = 0;
   localparam int HI   = 88;
   localparam int HIST = 4096;

   typedef struct {
      longint v;
      string  tag;
   } exp_t;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic signed [W-1:0] inc = '0;
   logic signed [W-1:0] y0;
   logic signed [W-1:0] y1;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   exp_t q0[$];
   exp_t q1[$];

   // model state, index 0 = depth 8, index 1 = depth 1
   int     dep [2] = '{8, 1};
   longint m_r [2];
   longint m_u [2];
   longint m_t [2];
   int     m_n [2];
   longint hist [2][HIST];

   always #(CLK_PERIOD/2) clk = ~clk;

   resid_clamp_acc #(.W(W), .GUARD(8), .LO(LO), .HI(HI), .DEPTH(8)) uut (
      .clk(clk), .rst(rst), .inc_i(inc), .y_o(y0));

   resid_clamp_acc #(.W(W), .GUARD(8), .LO(LO), .HI(HI), .DEPTH(1)) uut_d1 (
      .clk(clk), .rst(rst), .inc_i(inc), .y_o(y1));

   function automatic longint lim(longint v);
      if (v > HI) return HI;
      if (v < LO) return LO;
      return v;
   endfunction

   function automatic longint resid(longint r, longint p);
      longint rf;
      if (r > HI) begin
         rf = (p > HI) ? p : HI;
         return (rf - r < 0) ? rf - r : 0;
      end
      if (r < LO) begin
         rf = (p < LO) ? p : LO;
         return (rf - r > 0) ? rf - r : 0;
      end
      return 0;
   endfunction

   function automatic longint model_step(int k, longint d);
      longint inj, rn, rs;
      inj = (m_n[k] >= dep[k]) ? hist[k][m_n[k] - dep[k]] : 0;
      rn  = m_r[k] + d + inj;
      rs  = resid(rn, m_r[k]);
      m_r[k] = rn;
      m_u[k] += d;
      m_t[k] += rs;
      if (m_n[k] < HIST) hist[k][m_n[k]] = rs;
      m_n[k]++;
      return lim(m_u[k] + m_t[k]);
   endfunction

   function automatic void model_clear();
      for (int k = 0; k < 2; k++) begin
         m_r[k] = 0; m_u[k] = 0; m_t[k] = 0; m_n[k] = 0;
      end
   endfunction

   task automatic check(longint got, longint expv, string tag, string who);
      n_cmp++;
      if (got != expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, who, got, expv);
      end
   endtask

   // driver: one increment per clock, expectations pushed for both instances
   task automatic drive(longint d, string tag);
      exp_t e;
      @(negedge clk);
      inc = W'(d);
      e.tag = tag; e.v = model_step(0, d); q0.push_back(e);
      e.v = model_step(1, d); q1.push_back(e);
   endtask

   task automatic drive_exp(longint d, longint exp0, string tag);
      exp_t e;
      longint unused_v;
      @(negedge clk);
      inc = W'(d);
      unused_v = model_step(0, d);
      e.tag = tag; e.v = exp0; q0.push_back(e);
      e.v = model_step(1, d); q1.push_back(e);
   endtask

   task automatic do_reset();
      @(negedge clk);
      inc = '0;
      while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
      rst = 1'b1;
      model_clear();
      repeat (3) @(negedge clk);
      check(longint'(y0), 0, "R1", "uut during reset");
      rst = 1'b0;
      @(negedge clk);
      // no increment driven yet: value still the reset value one clock later
      check(longint'(y0), 0, "R1", "uut after reset");
      check(longint'(y1), 0, "R1", "uut_d1 after reset");
      model_step_idle();
   endtask

   // the clock after release ran with a zero increment: account for it
   function automatic void model_step_idle();
      longint unused_v;
      unused_v = model_step(0, 0);
      unused_v = model_step(1, 0);
   endfunction

   // monitor: pops expectations one clock after each drive
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (q0.size() != 0) begin
            e = q0.pop_front();
            check(longint'(y0), e.v, e.tag, "uut");
         end
         if (q1.size() != 0) begin
            e = q1.pop_front();
            check(longint'(y1), e.v, e.tag, "uut_d1");
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      model_clear();
      do_reset();

      // R2: running sum stays in range, output tracks it exactly
      drive_exp(10, 10, "R2");
      drive_exp(20, 30, "R2");
      drive_exp(-5, 25, "R2");
      drive_exp(30, 55, "R2");
      drive_exp(15, 70, "R2");
      drive_exp(-70, 0, "R2");
      drive_exp(88, 88, "R2");

      // R8 and R3: overshoot sequence with its accepted deviation
      do_reset();
      drive_exp(90, 88, "R8/R3");
      drive_exp(8, 88, "R8/R3");
      drive_exp(-1, 87, "R8/R3");
      drive_exp(2, 87, "R8/R3");
      // R6: residuals return to the raw sum but the output holds
      for (int i = 0; i < 12; i++) drive_exp(0, 87, "R6");

      // R4: below the lower bound
      do_reset();
      drive(-5, "R4");
      drive(-3, "R4");
      drive(6, "R4");
      drive(-20, "R4");
      drive(25, "R4");
      for (int i = 0; i < 10; i++) drive(0, "R6");

      // R7 and R3: large swings beyond both bounds
      do_reset();
      drive(300, "R7");
      drive(-500, "R7");
      drive(1000, "R7");
      drive(40, "R3");
      drive(-30, "R3");
      drive(-2000, "R7");
      drive(45, "R4");

      // R5: pseudo-random walk around the range
      do_reset();
      lfsr = 16'hACE1;
      for (int i = 0; i < 200; i++) begin
         int v;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         v = int'(lfsr[7:0]) % 81 - 40;
         if (i < 40) v = v + 15;
         drive(longint'(v), "R5");
      end

      @(negedge clk);
      inc = '0;
      while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule